// File: doc/BRIEF.md
# Pipeline Takeover Handshake Controller

This block lets a debug extension take a processor pipeline away from normal execution and hand it back later. It watches the instruction that sits in the decode stage. When that instruction is a break, or when the debug engine has asked for a suspend, the block claims the instruction with an active-low recognise signal. The claimed instruction is never executed.

The block then runs a four-signal exchange with the pipeline arbiter: recognise, enable, acknowledge and grant. While grant is high, the pipeline stays stalled. The decode-stage PC is saved as the address from which execution resumes. Once the stall is in place, the block tells the debug engine why it stopped, with a one-cycle pulse for a break or for a finished suspend.

A continue request from the debug engine gives the pipeline back. So does a low slot enable, which means the owning process has been descheduled. The block never claims a delay-slot instruction, so the saved PC is always a valid restart point.

Top module: `pipe_takeover_ctrl`

## Requirements
- R1: After reset, `rec_n` is high, `hold_ack` is low, and both event pulses are low.
- R2: In the idle state, with `slot_en` high and a valid decode instruction that is not in a delay slot, a break instruction drives `rec_n` low in the same cycle. An instruction is a break when `(instr & 32'hFC00003F) == 32'h0000000D`; bits 25:6 are free. No other instruction claims on its own.
- R3: If `rec_n` is low and `arb_en` is high at a rising edge, then after that edge `rec_n` is high, `hold_ack` is high, and `restart_pc` holds the `id_pc` sampled at that edge.
- R4: If `hold_ack` is high and `grant` is high at an edge, exactly one one-cycle pulse follows in the next cycle: `brk_evt` if the claim came from a break, `susp_done` if it came from a suspend. `hold_ack` then stays high until a release.
- R5: A `susp_req` sampled at an edge while idle makes `rec_n` go low in the following cycle, whatever the instruction is, as long as the instruction is valid and not in a delay slot.
- R6: While `id_delay_slot` is high, `rec_n` stays high. A pending suspend is kept and is claimed once the delay slot has passed.
- R7: A `resume_req` sampled at an edge while the stall is held drops `hold_ack` after that edge.
- R8: While `slot_en` is low, `rec_n` is high. After the next edge `hold_ack` is low, and any pending suspend is discarded.
- R9: While `arb_en` stays low, a claim stays pending: `rec_n` stays low and `hold_ack` stays low.
- R10: A `susp_req` that arrives while the stall is held has no effect. It produces no pulse and no new claim after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline synchronisation clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | Extension slot enabled; the owning process is scheduled |
| id_valid | input | 1 | Decode stage holds a valid instruction |
| id_instr | input | XLEN | Instruction in the decode stage |
| id_pc | input | XLEN | PC of the decode-stage instruction |
| id_delay_slot | input | 1 | Decode instruction is in a branch delay slot |
| susp_req | input | 1 | Suspend request from the debug engine |
| resume_req | input | 1 | Continue request from the debug engine |
| arb_en | input | 1 | Arbiter enable answering a claim |
| grant | input | 1 | Arbiter grant; the pipeline is stalled while high |
| rec_n | output | 1 | Active-low recognise-instruction claim |
| hold_ack | output | 1 | Acknowledge that holds the pipeline |
| restart_pc | output | XLEN | Saved restart address |
| susp_done | output | 1 | One-cycle pulse: the suspend stall is in place |
| brk_evt | output | 1 | One-cycle pulse: a break stall is in place |

## Verification
The assertions check the following on every cycle:
- the acknowledge only rises after an enabled claim;
- no claim is made on a delay-slot instruction;
- the event pulses are exclusive and only follow a grant;
- a held stall persists until a release;
- a release or a low slot enable drops the acknowledge.

Other behaviour can only be shown by the bench's scenarios:
- the saved restart address;
- the one-cycle delay on a suspend;
- a pending suspend that survives a delay slot but not a slot disable;
- a suspend ignored while held;
- break decoding over random instruction words.

// File: rtl/pipe_takeover_ctrl.sv
module pipe_takeover_ctrl #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] BRK_MASK  = 32'hFC00003F,
  parameter logic [XLEN-1:0] BRK_MATCH = 32'h0000000D
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slot_en,
  input  logic            id_valid,
  input  logic [XLEN-1:0] id_instr,
  input  logic [XLEN-1:0] id_pc,
  input  logic            id_delay_slot,
  input  logic            susp_req,
  input  logic            resume_req,
  input  logic            arb_en,
  input  logic            grant,
  output logic            rec_n,
  output logic            hold_ack,
  output logic [XLEN-1:0] restart_pc,
  output logic            susp_done,
  output logic            brk_evt
);

  typedef enum logic [1:0] {ST_IDLE, ST_ENGAGE, ST_HELD} st_t;

  st_t  state;
  logic pend;
  logic by_brk;
  logic is_brk;
  logic claim;

  assign is_brk   = (id_instr & BRK_MASK) == BRK_MATCH;
  assign claim    = slot_en && state == ST_IDLE && id_valid && !id_delay_slot && (is_brk || pend);
  assign rec_n    = !claim;
  assign hold_ack = state != ST_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      pend       <= 1'b0;
      by_brk     <= 1'b0;
      restart_pc <= '0;
      susp_done  <= 1'b0;
      brk_evt    <= 1'b0;
    end else begin
      susp_done <= 1'b0;
      brk_evt   <= 1'b0;
      if (!slot_en) begin
        state <= ST_IDLE;
        pend  <= 1'b0;
      end else begin
        case (state)
          ST_IDLE:
            if (claim && arb_en) begin
              state      <= ST_ENGAGE;
              restart_pc <= id_pc;
              by_brk     <= is_brk;
              pend       <= 1'b0;
            end else if (susp_req) begin
              pend <= 1'b1;
            end
          ST_ENGAGE:
            if (grant) begin
              state <= ST_HELD;
              if (by_brk) brk_evt <= 1'b1;
              else        susp_done <= 1'b1;
            end
          ST_HELD:
            if (resume_req) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_ack_after_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> $past(!rec_n && arb_en));

  assert_no_ds_claim_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_n |-> !id_delay_slot);

  assert_pulse_after_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_done || brk_evt) |-> ($past(grant) && hold_ack));

  assert_pulses_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({susp_done, brk_evt}));

  assert_hold_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HELD && slot_en && !resume_req) |=> hold_ack);

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HELD && resume_req) |=> !hold_ack);

  assert_slot_off_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |=> !hold_ack);

  assert_slot_off_claim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |-> rec_n);

endmodule

// File: tb/test_pipe_takeover_ctrl.sv
module test_pipe_takeover_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] NOP = 32'h00000000;
  localparam logic [31:0] BRK = 32'h0000000D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_en = 1'b0, id_valid = 1'b0, id_delay_slot = 1'b0;
  logic susp_req = 1'b0, resume_req = 1'b0, arb_allow = 1'b0;
  logic [31:0] id_instr = NOP, id_pc = '0;
  logic arb_en, grant, rec_n, hold_ack, susp_done, brk_evt;
  logic [31:0] restart_pc;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign arb_en = !rec_n && arb_allow;
  always_ff @(posedge clk) grant <= rst_n ? hold_ack : 1'b0;

  pipe_takeover_ctrl i_pipe_takeover_ctrl (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .id_valid(id_valid),
    .id_instr(id_instr), .id_pc(id_pc), .id_delay_slot(id_delay_slot),
    .susp_req(susp_req), .resume_req(resume_req), .arb_en(arb_en), .grant(grant),
    .rec_n(rec_n), .hold_ack(hold_ack), .restart_pc(restart_pc),
    .susp_done(susp_done), .brk_evt(brk_evt));

  function automatic logic exp_brk(logic [31:0] w);
    return (w & 32'hFC00003F) == 32'h0000000D;
  endfunction

  function automatic logic exp_rec_n(logic v, logic ds, logic [31:0] w);
    return !(v && !ds && exp_brk(w));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    check("R1 rec_n", rec_n, 1);
    check("R1 ack", hold_ack, 0);
    check("R1 pulses", {susp_done, brk_evt}, 0);
    rst_n = 1; slot_en = 1; arb_allow = 1; id_valid = 1;
    tick();

    id_instr = BRK | 32'h00ABC0; id_pc = 32'h100; #1;
    check("R2 break claim", rec_n, 0);
    tick();
    id_instr = NOP; id_pc = 32'h104; #1;
    check("R3 rec_n released", rec_n, 1);
    check("R3 ack", hold_ack, 1);
    check("R3 restart_pc", restart_pc, 32'h100);
    tick();
    check("R4 no early pulse", {susp_done, brk_evt}, 0);
    tick();
    check("R4 brk_evt", {susp_done, brk_evt}, 2'b01);
    tick();
    check("R4 pulse one cycle", {susp_done, brk_evt}, 0);
    check("R4 ack held", hold_ack, 1);
    resume_req = 1; tick(); resume_req = 0; #1;
    check("R7 ack dropped", hold_ack, 0);
    tick();

    id_pc = 32'h200; susp_req = 1; #1;
    check("R5 not same cycle", rec_n, 1);
    tick(); susp_req = 0; #1;
    check("R5 claim next cycle", rec_n, 0);
    tick();
    check("R3 restart_pc suspend", restart_pc, 32'h200);
    tick(2);
    check("R4 susp_done", {susp_done, brk_evt}, 2'b10);
    susp_req = 1; tick(); susp_req = 0; tick(2);
    check("R10 no pulse while held", {susp_done, brk_evt}, 0);
    resume_req = 1; tick(); resume_req = 0; #1;
    check("R10 no stale claim", rec_n, 1);
    tick(2);
    check("R10 still idle", {rec_n, hold_ack}, 2'b10);

    id_pc = 32'h300; id_delay_slot = 1; susp_req = 1; tick(); susp_req = 0; #1;
    check("R6 no claim in delay slot", rec_n, 1);
    tick();
    check("R6 still waiting", rec_n, 1);
    id_delay_slot = 0; #1;
    check("R6 pending claimed", rec_n, 0);
    tick();
    check("R6 restart_pc", restart_pc, 32'h300);
    tick(3);
    check("R8 held before drop", hold_ack, 1);
    slot_en = 0; #1;
    check("R8 rec_n high", rec_n, 1);
    tick();
    check("R8 ack dropped", hold_ack, 0);
    slot_en = 1; tick(2);

    id_delay_slot = 1; susp_req = 1; tick(); susp_req = 0;
    slot_en = 0; tick(); slot_en = 1; id_delay_slot = 0; #1;
    check("R8 pending discarded", rec_n, 1);
    tick();

    arb_allow = 0; id_instr = BRK;
    for (int k = 0; k < 3; k++) begin
      #1;
      check("R9 claim kept", {rec_n, hold_ack}, 2'b00);
      tick();
    end
    id_instr = NOP; tick();

    for (int k = 0; k < 300; k++) begin
      logic [31:0] w;
      w = $urandom;
      if (w[0]) w = (w & ~32'hFC00003F) | 32'h0000000D;
      id_instr = w;
      id_valid = $urandom_range(0, 3) != 0;
      id_delay_slot = $urandom_range(0, 3) == 0;
      #1;
      check("R2 random decode", rec_n, exp_rec_n(id_valid, id_delay_slot, w));
      check("R9 random no ack", hold_ack, 0);
      tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule